// File: doc/BRIEF.md
# Single-Wire Sync Pulse Speed Measurer

This block is the host side of a speed discovery step on a single-wire, open-drain debug line. On a start strobe it pulls the shared line low long enough for the slowest target to notice. It then drives the line high for a short speedup pulse to sharpen the rising edge, and releases the line. The target answers by holding the line low for 128 of its own bit-clock cycles. The block times that low pulse in host clocks and divides the count by 128, rounded to the nearest whole value. The result is the number of host clocks per target bit, which is used for all later traffic on the link.

The sampled pin passes through a two-flop synchronizer. Edges are found on the synchronized level. If no reply starts within a set window after release, the block raises a timeout flag and keeps the previous result. A few percent of error in the result is acceptable for the link.

Top module: `sync_speed_probe`

## Requirements
- R1: While reset is asserted and after it is released, line_oe_o, busy_o, done_o and timeout_o are 0, and low_cnt_o and bit_period_o are 0.
- R2: A start_i pulse seen while idle makes the block drive the line low (line_oe_o=1, line_drv_o=0) for exactly REQ_CLKS cycles, where REQ_CLKS = ceil(128 * HOST_KHZ / MIN_TGT_KHZ). This starts in the cycle after the one in which start_i is sampled.
- R3: The low request is followed at once by SPEEDUP_CLKS cycles of driving high (line_oe_o=1, line_drv_o=1). After that line_oe_o stays 0 until the next request.
- R4: start_i is ignored while busy_o is 1. A start pulse in the middle of the request neither restarts nor lengthens it.
- R5: low_cnt_o is set to the number of consecutive host cycles the line is sampled low during the reply. The count is measured after a two-flop synchronizer. done_o pulses for one cycle when the count is stored, and busy_o is 0 from that cycle on.
- R6: bit_period_o equals (low_cnt_o + 64) >> 7, which rounds the count divided by 128 to the nearest value. For example, 191 gives 1 and 192 gives 2.
- R7: The reply count saturates at 2^CNT_W - 1 and does not wrap.
- R8: If the synchronized line shows no falling edge within TIMEOUT_CLKS cycles, counted from the first released cycle, the block goes idle and sets timeout_o. timeout_o stays set until the next accepted start. In that case done_o does not pulse, and low_cnt_o and bit_period_o keep their previous values.
- R9: A falling edge that the synchronized line shows in the last cycle of the window counts as a reply and wins over the timeout. The same edge one cycle later gives a timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to run a speed measurement |
| line_i | input | 1 | Sampled level of the shared line (asynchronous) |
| line_oe_o | output | 1 | 1 = host drives the line |
| line_drv_o | output | 1 | Level driven when line_oe_o is 1 |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | One-cycle pulse when a new result is stored |
| timeout_o | output | 1 | No reply arrived in the window of the last run |
| low_cnt_o | output | CNT_W | Measured reply low time in host clocks |
| bit_period_o | output | CNT_W-6 | Host clocks per target bit, rounded |

## Verification
The end of the reply window and the arrival of the reply's falling edge can fall in the same cycle. This is the contest that R9 settles. The bench counts host cycles from the first released cycle and pulls the line low so that the synchronized level first reads low exactly in the last window cycle. It expects a stored count and a done pulse with no timeout. It then repeats the run with the pull one cycle later and expects the timeout, with the earlier result left unchanged.

// File: rtl/sprobe_pkg.sv
// Shared types for the sync pulse speed measurer.
package sprobe_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // line released, waiting for start
        ST_REQ,    // host pulls the line low
        ST_SPD,    // host drives a short high speedup pulse
        ST_WAIT,   // line released, waiting for reply falling edge
        ST_MEAS    // timing the reply low pulse
    } probe_st_t;
endpackage

// File: rtl/sprobe_line_sync.sv
// Two-flop synchronizer for the shared line, with falling-edge detection.
// Assumes the idle line is high, so all stages reset to 1 and no false edge
// is reported after reset.
module sprobe_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic lvl_o,
    output logic fall_o
);
    logic s1_q, s2_q, s3_q;

    // Shift the asynchronous pin through the sync stages and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
            s3_q <= 1'b1;
        end else begin
            s1_q <= pin_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    // Level and high-to-low transition of the synchronized line.
    always_comb begin
        lvl_o  = s2_q;
        fall_o = s3_q & ~s2_q;
    end
endmodule

// File: rtl/sprobe_fsm.sv
// Sequencer: issues the low request and the speedup pulse, releases the line,
// waits a bounded window for the reply, and counts reply low cycles.
// Assumes lvl_i/fall_i come from a synchronizer and that the *_CLKS values are >= 1.
module sprobe_fsm
    import sprobe_pkg::*;
#(
    parameter int REQ_CLKS = 128,
    parameter int SPD_CLKS = 1,
    parameter int TMO_CLKS = 1000,
    parameter int CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             lvl_i,
    input  logic             fall_i,
    output logic             oe_o,
    output logic             drv_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             tmo_o,
    output logic             cap_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int MAX_T = (REQ_CLKS > TMO_CLKS) ?
                           ((REQ_CLKS > SPD_CLKS) ? REQ_CLKS : SPD_CLKS) :
                           ((TMO_CLKS > SPD_CLKS) ? TMO_CLKS : SPD_CLKS);
    localparam int TMR_W = $clog2(MAX_T + 1);
    localparam logic [TMR_W-1:0] REQ_LAST = TMR_W'(REQ_CLKS - 1);
    localparam logic [TMR_W-1:0] SPD_LAST = TMR_W'(SPD_CLKS - 1);
    localparam logic [TMR_W-1:0] TMO_LAST = TMR_W'(TMO_CLKS - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    probe_st_t        st_q;
    logic [TMR_W-1:0] tmr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q, tmo_q;

    // Reply ends when the synchronized line reads high again during measurement.
    always_comb begin
        cap_o  = (st_q == ST_MEAS) && lvl_i;
        oe_o   = (st_q == ST_REQ) || (st_q == ST_SPD);
        drv_o  = (st_q == ST_SPD);
        busy_o = (st_q != ST_IDLE);
        done_o = done_q;
        tmo_o  = tmo_q;
        cnt_o  = cnt_q;
    end

    // State, phase timer, reply counter and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            tmr_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
            tmo_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        st_q  <= ST_REQ;
                        tmr_q <= '0;
                        tmo_q <= 1'b0;
                    end
                end
                ST_REQ: begin
                    if (tmr_q == REQ_LAST) begin
                        st_q  <= ST_SPD;
                        tmr_q <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ST_SPD: begin
                    if (tmr_q == SPD_LAST) begin
                        st_q  <= ST_WAIT;
                        tmr_q <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (fall_i) begin
                        st_q  <= ST_MEAS;
                        cnt_q <= CNT_W'(1);
                    end else if (tmr_q == TMO_LAST) begin
                        st_q  <= ST_IDLE;
                        tmo_q <= 1'b1;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ST_MEAS: begin
                    if (lvl_i) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                    end else if (cnt_q != CNT_MAX) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sprobe_period.sv
// Result register: holds the reply low count and the rounded count/128.
// Assumes CNT_W >= 8; updates only on the capture strobe.
module sprobe_period #(
    parameter int CNT_W = 16,
    parameter int PER_W = CNT_W - 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] low_cnt_o,
    output logic [PER_W-1:0] period_o
);
    localparam logic [CNT_W:0] HALF = (CNT_W+1)'(64);

    logic [CNT_W:0] sum;

    // Add half a divisor so the shift rounds to nearest.
    always_comb sum = {1'b0, cnt_i} + HALF;

    // Store count and period together when a reply completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt_o <= '0;
            period_o  <= '0;
        end else if (cap_i) begin
            low_cnt_o <= cnt_i;
            period_o  <= sum[CNT_W:7];
        end
    end
endmodule

// File: rtl/sync_speed_probe.sv
// Top of the sync pulse speed measurer. Derives the request length from the
// host and slowest target clock rates, and wires synchronizer, sequencer and
// result register together. Assumes an external open-drain pad with pull-up.
module sync_speed_probe #(
    parameter int HOST_KHZ     = 100000,
    parameter int MIN_TGT_KHZ  = 1000,
    parameter int SPEEDUP_CLKS = 1,
    parameter int TIMEOUT_CLKS = 100000,
    parameter int CNT_W        = 16,
    parameter int PER_W        = CNT_W - 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             line_i,
    output logic             line_oe_o,
    output logic             line_drv_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             timeout_o,
    output logic [CNT_W-1:0] low_cnt_o,
    output logic [PER_W-1:0] bit_period_o
);
    localparam int REQ_CLKS = (128 * HOST_KHZ + MIN_TGT_KHZ - 1) / MIN_TGT_KHZ;

    logic             lvl, fall, cap;
    logic [CNT_W-1:0] cnt;

    sprobe_line_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (line_i),
        .lvl_o  (lvl),
        .fall_o (fall)
    );

    sprobe_fsm #(
        .REQ_CLKS (REQ_CLKS),
        .SPD_CLKS (SPEEDUP_CLKS),
        .TMO_CLKS (TIMEOUT_CLKS),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .lvl_i   (lvl),
        .fall_i  (fall),
        .oe_o    (line_oe_o),
        .drv_o   (line_drv_o),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .tmo_o   (timeout_o),
        .cap_o   (cap),
        .cnt_o   (cnt)
    );

    sprobe_period #(
        .CNT_W (CNT_W),
        .PER_W (PER_W)
    ) u_per (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_i     (cap),
        .cnt_i     (cnt),
        .low_cnt_o (low_cnt_o),
        .period_o  (bit_period_o)
    );
endmodule

// File: rtl/sync_speed_probe_chk.sv
// Checker for the sync pulse speed measurer, bound to every instance of the top.
module sync_speed_probe_chk #(
    parameter int CNT_W = 16,
    parameter int PER_W = CNT_W - 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             line_oe_o,
    input logic             line_drv_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             timeout_o,
    input logic [CNT_W-1:0] low_cnt_o,
    input logic [PER_W-1:0] bit_period_o
);
    // R3
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !line_oe_o);

    // R3
    no_low_after_speedup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe_o && line_drv_o) |=> !(line_oe_o && !line_drv_o));

    // R4
    busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R8
    result_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(low_cnt_o));

    // R8
    done_excl_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !timeout_o && !busy_o);

    // R6
    period_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ({{(32-PER_W){1'b0}}, bit_period_o} == ((32'(low_cnt_o) + 32'd64) >> 7)));
endmodule

bind sync_speed_probe sync_speed_probe_chk #(.CNT_W(CNT_W), .PER_W(PER_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .line_oe_o    (line_oe_o),
    .line_drv_o   (line_drv_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .timeout_o    (timeout_o),
    .low_cnt_o    (low_cnt_o),
    .bit_period_o (bit_period_o)
);

// File: tb/sim_sync_speed_probe.sv
// Directed bench for the sync pulse speed measurer; one task per scenario.
module sim_sync_speed_probe;
    localparam int HOST = 1000;
    localparam int MINT = 1000;
    localparam int SPD  = 2;
    localparam int TMO  = 40;
    localparam int CW   = 12;
    localparam int PW   = CW - 6;
    localparam int REQ  = (128 * HOST + MINT - 1) / MINT;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          tgt_low = 1'b0;
    logic          line;
    logic          oe, drv, busy, done, tmo;
    logic [CW-1:0] low_cnt;
    logic [PW-1:0] per;

    int errs = 0;
    int checks = 0;
    int cyc = 0;

    always #2 clk = ~clk;  // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    // Open-drain line with pull-up: host drive wins, else target may pull low.
    assign line = oe ? drv : ~tgt_low;

    sync_speed_probe #(
        .HOST_KHZ (HOST), .MIN_TGT_KHZ (MINT), .SPEEDUP_CLKS (SPD),
        .TIMEOUT_CLKS (TMO), .CNT_W (CW)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .start_i (start), .line_i (line),
        .line_oe_o (oe), .line_drv_o (drv), .busy_o (busy), .done_o (done),
        .timeout_o (tmo), .low_cnt_o (low_cnt), .bit_period_o (per)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat(input int n);
        return (n > (1 << CW) - 1) ? (1 << CW) - 1 : n;
    endfunction

    // Pulse start, then measure request and speedup lengths; optional poke while busy.
    task automatic request(input bit poke);
        int lo = 0;
        int hi = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (oe && !drv) begin
            lo++;
            if (poke && lo == 5) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        while (oe && drv) begin
            hi++;
            @(negedge clk);
        end
        chk(poke ? "R4 request length with start while busy" : "R2 request low length", lo, REQ);
        chk("R3 speedup length", hi, SPD);
        chk("R3 released after speedup", oe, 0);
    endtask

    // Target pulls low for n cycles after a short delay; expects a stored count.
    task automatic measure(input int n, input bit poke);
        bit seen = 0;
        request(poke);
        repeat (4) @(negedge clk);
        tgt_low = 1'b1;
        repeat (n) @(negedge clk);
        tgt_low = 1'b0;
        for (int i = 0; i < 10 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        chk("R5 done pulse seen", seen, 1);
        chk(n > (1 << CW) - 1 ? "R7 saturated count" : "R5 low count", low_cnt, sat(n));
        chk("R6 rounded period", per, (sat(n) + 64) >> 7);
        @(negedge clk);
        chk("R5 done lasts one cycle", done, 0);
        chk("R5 busy cleared", busy, 0);
        chk("R8 no timeout", tmo, 0);
    endtask

    // Pull starts `lead` cycles after the first released cycle; lasts n cycles.
    task automatic window_edge(input int lead, input int n, input bit expect_ok);
        bit seen = 0;
        int old_cnt = low_cnt;
        int old_per = per;
        request(0);  // now in the first released cycle
        repeat (lead) @(negedge clk);
        tgt_low = 1'b1;
        repeat (n) @(negedge clk);
        tgt_low = 1'b0;
        for (int i = 0; i < 10 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        repeat (3) @(negedge clk);
        if (expect_ok) begin
            chk("R9 edge in last window cycle gives done", seen, 1);
            chk("R9 count stored", low_cnt, n);
            chk("R9 no timeout", tmo, 0);
        end else begin
            chk("R9 edge after window gives timeout", tmo, 1);
            chk("R8 no done on timeout", seen, 0);
            chk("R8 count kept", low_cnt, old_cnt);
            chk("R8 period kept", per, old_per);
            chk("R8 idle after timeout", busy, 0);
        end
    endtask

    // No reply at all: timeout, result kept, flag held until next start.
    task automatic silent();
        int old_cnt = low_cnt;
        request(0);
        repeat (TMO + 5) @(negedge clk);
        chk("R8 timeout flag", tmo, 1);
        chk("R8 idle after timeout", busy, 0);
        chk("R8 count kept", low_cnt, old_cnt);
        repeat (5) @(negedge clk);
        chk("R8 flag held", tmo, 1);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R8 flag cleared by start", tmo, 0);
        repeat (REQ + SPD + TMO + 10) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 oe in reset", oe, 0);
        chk("R1 busy in reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", done, 0);
        chk("R1 timeout after reset", tmo, 0);
        chk("R1 count after reset", low_cnt, 0);
        chk("R1 period after reset", per, 0);
        measure(128, 1);
        measure(191, 0);
        measure(192, 0);
        measure(63, 0);
        measure(1280, 0);
        measure(5000, 0);
        silent();
        measure(300, 0);
        window_edge(TMO - 3, 50, 1);
        window_edge(TMO - 2, 20, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule